// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a 16384-bit memory with one write port and one read port. Each port has its own clock and clock enable. Each port's data width is fixed by a parameter, so data can go in at one width and come out at another. Both ports address the same 14-bit bit-granular space. The low address bits that fall inside one word of a port are ignored, so every access is aligned to that port's width.

The read path always has a first register that captures the addressed word. A parameter can add a second output register with its own enable. A reset input clears the output registers, and a parameter decides whether that reset is synchronous or asynchronous. The reset never touches the stored data.

A three-bit select input must match a parameter before any write or first-register load takes effect. This lets several instances share address and data buses and be tiled into a deeper memory. The power-up contents come from a parameter made of 64 segments of 256 bits.

Top module: `sdp_mixed_ram`

## Requirements
- R1: For a port of width W (1, 2, 4, 8, 16 or 32, set separately for write and read), word n covers bits n*W to n*W+W-1 of one 16384-bit array, so data written at one width reads back at the other width from the same bit positions.
- R2: The low log2(W) bits of each port's 14-bit address are ignored.
- R3: With READ_PIPE=0, rd_data shows the addressed read word one rd_clk edge after an edge where rd_ce=1 and blk_sel matches.
- R4: With READ_PIPE=1, a second register loads the first register's value on each rd_clk edge where rd_oce=1 and holds otherwise; rd_data reads this second register.
- R5: An active rd_rst clears the output registers to zero and leaves the stored contents unchanged.
- R6: When blk_sel differs from BLOCK_ID, no write happens and the first read register holds its value.
- R7: With wr_ce=0 no write happens; with rd_ce=0 the first read register holds its value.
- R8: When the same clock drives both ports and the read and write address the same bits in one cycle, the read returns the contents from before the write.
- R9: Bits of rd_data at positions RD_WIDTH and above are always zero.
- R10: Segment k of INIT_WORDS sets the initial value of bits k*256 to k*256+255.
- R11: With wr_en=0 (read request) the write port changes nothing, even with wr_ce=1.
- R12: With ASYNC_RESET=1, rd_rst clears the outputs at once, with no clock edge. With the default ASYNC_RESET=0, the outputs clear only at an rd_clk edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| blk_sel | input | 3 | Block select, compared with BLOCK_ID |
| wr_clk | input | 1 | Write port clock |
| wr_ce | input | 1 | Write port clock enable |
| wr_en | input | 1 | 1 = write, 0 = no write |
| wr_addr | input | 14 | Write bit address |
| wr_data | input | 32 | Write data, low WR_WIDTH bits used |
| rd_clk | input | 1 | Read port clock |
| rd_rst | input | 1 | Clears the read output registers, active high |
| rd_ce | input | 1 | Read port clock enable for the first register |
| rd_oce | input | 1 | Enable for the second output register |
| rd_addr | input | 14 | Read bit address |
| rd_data | output | 32 | Read data, zero above RD_WIDTH |

## Verification
Two instances run side by side:
- A bypass instance with sync reset, writing 4 bits and reading 16.
- A pipelined instance with async reset, writing 32 bits and reading 2.

Random writes and reads confined to a narrow address window show whether narrow writes land in the right lanes of wider reads. Random low address bits show whether the ignored bits are truly ignored. Reads over untouched addresses separate correct initial contents from a wrong segment order.

Directed cases each isolate one behaviour:
- A same-address write and read in one cycle separates read-before-write from write-first.
- Cycles with a mismatched select, a low enable or a read request show whether each gate really blocks a write or a register load.
- Toggling the output enable separates the two read registers.
- Asserting reset between edges separates the synchronous reset from the asynchronous one.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int unsigned ADDR_W        = 14;
    localparam int unsigned BUS_W         = 32;
    localparam int unsigned TOTAL_BITS    = 1 << ADDR_W;
    localparam int unsigned OFF_W         = $clog2(BUS_W);
    localparam int unsigned WORD_CNT      = TOTAL_BITS / BUS_W;
    localparam int unsigned WORD_IDX_W    = ADDR_W - OFF_W;
    localparam int unsigned INIT_SEG_BITS = 256;
    localparam int unsigned INIT_SEGS     = TOTAL_BITS / INIT_SEG_BITS;

    typedef logic [BUS_W-1:0]      bus_t;
    typedef logic [ADDR_W-1:0]     addr_t;
    typedef logic [WORD_IDX_W-1:0] widx_t;
    typedef logic [OFF_W-1:0]      off_t;

    // Location of an aligned port word inside the 32-bit storage rows.
    typedef struct packed {
        widx_t idx;
        off_t  off;
    } bitloc_t;

    // Read-side register pair.
    typedef struct packed {
        bus_t stage1;
        bus_t stage2;
    } rd_state_t;

    function automatic bitloc_t locate(addr_t addr, int unsigned lg);
        addr_t   aligned;
        bitloc_t loc;
        aligned  = addr & ~((addr_t'(1) << lg) - addr_t'(1));
        loc.idx  = aligned[ADDR_W-1:OFF_W];
        loc.off  = aligned[OFF_W-1:0];
        return loc;
    endfunction

    function automatic bus_t lane_mask(int unsigned w);
        if (w >= BUS_W) begin
            return '1;
        end
        return bus_t'((64'd1 << w) - 64'd1);
    endfunction

    function automatic bit width_ok(int unsigned w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
    endfunction

endpackage

// File: rtl/sdp_wr_port.sv
module sdp_wr_port
    import sdp_pkg::*;
#(
    parameter int unsigned WR_WIDTH = 32,
    parameter logic [2:0]  BLOCK_ID = 3'd0
) (
    input  logic [2:0] blk_sel,
    input  logic       wr_ce,
    input  logic       wr_en,
    input  addr_t      wr_addr,
    input  bus_t       wr_data,
    output logic       wr_fire,
    output widx_t      wr_idx,
    output bus_t       wr_mask,
    output bus_t       wr_bits
);

    localparam int unsigned WR_LG = $clog2(WR_WIDTH);

    bitloc_t loc;
    bus_t    lane;

    always_comb begin
        loc     = locate(wr_addr, WR_LG);
        lane    = lane_mask(WR_WIDTH);
        wr_idx  = loc.idx;
        wr_mask = lane << loc.off;
        wr_bits = (wr_data & lane) << loc.off;
        // R6, R7, R11: all three gates must pass
        wr_fire = wr_ce & wr_en & (blk_sel == BLOCK_ID);
    end

    // R1 / R2: a firing write touches exactly one aligned lane of WR_WIDTH bits
    always_comb begin
        if (!$isunknown(wr_fire) && wr_fire) begin
            a_r2_lane_aligned: assert ((int'(loc.off) % WR_WIDTH) == 0 &&
                                       $countones(wr_mask) == WR_WIDTH)
                else $error("write lane misaligned");
        end
    end

endmodule

// File: rtl/sdp_storage.sv
module sdp_storage
    import sdp_pkg::*;
#(
    parameter logic [INIT_SEGS-1:0][INIT_SEG_BITS-1:0] INIT_WORDS = '0
) (
    input  logic  wr_clk,
    input  logic  wr_fire,
    input  widx_t wr_idx,
    input  bus_t  wr_mask,
    input  bus_t  wr_bits,
    input  widx_t rd_idx,
    output bus_t  rd_word
);

    localparam logic [TOTAL_BITS-1:0] INIT_FLAT = INIT_WORDS;

    bus_t mem [WORD_CNT];

    // R10: segment k maps onto bits k*256 upward, so row i takes bits i*32 upward
    initial begin
        for (int i = 0; i < int'(WORD_CNT); i++) begin
            mem[i] = INIT_FLAT[i*BUS_W +: BUS_W];
        end
    end

    // Masked merge keeps the bits outside the written lane
    always_ff @(posedge wr_clk) begin
        if (wr_fire) begin
            mem[wr_idx] <= (mem[wr_idx] & ~wr_mask) | (wr_bits & wr_mask);
        end
    end

    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/sdp_rd_port.sv
module sdp_rd_port
    import sdp_pkg::*;
#(
    parameter int unsigned RD_WIDTH    = 32,
    parameter bit          READ_PIPE   = 1'b0,
    parameter bit          ASYNC_RESET = 1'b0,
    parameter logic [2:0]  BLOCK_ID    = 3'd0
) (
    input  logic       rd_clk,
    input  logic       rd_rst,
    input  logic       rd_ce,
    input  logic       rd_oce,
    input  logic [2:0] blk_sel,
    input  addr_t      rd_addr,
    input  bus_t       rd_word,
    output widx_t      rd_idx,
    output bus_t       rd_data
);

    localparam int unsigned RD_LG   = $clog2(RD_WIDTH);
    localparam bus_t        RD_LANE = lane_mask(RD_WIDTH);

    bitloc_t   loc;
    bus_t      lane_val;
    logic      load1;
    rd_state_t st_d;
    rd_state_t st_q;

    always_comb begin
        loc      = locate(rd_addr, RD_LG);
        rd_idx   = loc.idx;
        lane_val = (rd_word >> loc.off) & RD_LANE;
        load1    = rd_ce & (blk_sel == BLOCK_ID);
    end

    always_comb begin
        st_d = st_q;
        if (load1) begin
            st_d.stage1 = lane_val;
        end
        if (READ_PIPE && rd_oce) begin
            st_d.stage2 = st_q.stage1;
        end
    end

    generate
        if (ASYNC_RESET) begin : g_async_rst
            always_ff @(posedge rd_clk or posedge rd_rst) begin
                if (rd_rst) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_sync_rst
            always_ff @(posedge rd_clk) begin
                if (rd_rst) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end

        if (READ_PIPE) begin : g_pipe_out
            assign rd_data = st_q.stage2;
        end else begin : g_bypass_out
            assign rd_data = st_q.stage1;
        end
    endgenerate

    // R5: a sampled reset leaves zero on the output at the next edge
    a_r5_reset_clears: assert property (@(posedge rd_clk)
        rd_rst |=> (rd_data == '0))
        else $error("output not cleared by reset");

    // R7: first register holds while the read clock enable is low
    a_r7_ce_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_ce |=> $stable(st_q.stage1))
        else $error("stage1 moved with rd_ce low");

    // R6: first register holds while another block is selected
    a_r6_blk_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (blk_sel != BLOCK_ID) |=> $stable(st_q.stage1))
        else $error("stage1 moved with block deselected");

    // R4: second register holds unless enabled in pipeline mode
    a_r4_out_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(READ_PIPE && rd_oce) |=> $stable(st_q.stage2))
        else $error("stage2 moved without enable");

    // R4: second register takes the first register's previous value
    a_r4_out_follow: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (READ_PIPE && rd_oce) |=> (st_q.stage2 == $past(st_q.stage1)))
        else $error("stage2 did not follow stage1");

    // R9: nothing above the configured read width
    a_r9_upper_zero: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_data & ~RD_LANE) == '0)
        else $error("rd_data has bits above RD_WIDTH");

endmodule

// File: rtl/sdp_mixed_ram.sv
module sdp_mixed_ram
    import sdp_pkg::*;
#(
    parameter int unsigned WR_WIDTH    = 32,
    parameter int unsigned RD_WIDTH    = 32,
    parameter bit          READ_PIPE   = 1'b0,
    parameter bit          ASYNC_RESET = 1'b0,
    parameter logic [2:0]  BLOCK_ID    = 3'd0,
    parameter logic [INIT_SEGS-1:0][INIT_SEG_BITS-1:0] INIT_WORDS = '0
) (
    input  logic [2:0]  blk_sel,
    input  logic        wr_clk,
    input  logic        wr_ce,
    input  logic        wr_en,
    input  logic [13:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_clk,
    input  logic        rd_rst,
    input  logic        rd_ce,
    input  logic        rd_oce,
    input  logic [13:0] rd_addr,
    output logic [31:0] rd_data
);

    logic  wr_fire;
    widx_t wr_idx;
    bus_t  wr_mask;
    bus_t  wr_bits;
    widx_t rd_idx;
    bus_t  rd_word;

    // R1: only the listed port widths are legal
    initial begin
        a_r1_width_legal: assert (width_ok(WR_WIDTH) && width_ok(RD_WIDTH))
            else $error("illegal port width");
    end

    sdp_wr_port #(
        .WR_WIDTH (WR_WIDTH),
        .BLOCK_ID (BLOCK_ID)
    ) i_wr_port (
        .blk_sel (blk_sel),
        .wr_ce   (wr_ce),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_fire (wr_fire),
        .wr_idx  (wr_idx),
        .wr_mask (wr_mask),
        .wr_bits (wr_bits)
    );

    sdp_storage #(
        .INIT_WORDS (INIT_WORDS)
    ) i_storage (
        .wr_clk  (wr_clk),
        .wr_fire (wr_fire),
        .wr_idx  (wr_idx),
        .wr_mask (wr_mask),
        .wr_bits (wr_bits),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    sdp_rd_port #(
        .RD_WIDTH    (RD_WIDTH),
        .READ_PIPE   (READ_PIPE),
        .ASYNC_RESET (ASYNC_RESET),
        .BLOCK_ID    (BLOCK_ID)
    ) i_rd_port (
        .rd_clk  (rd_clk),
        .rd_rst  (rd_rst),
        .rd_ce   (rd_ce),
        .rd_oce  (rd_oce),
        .blk_sel (blk_sel),
        .rd_addr (rd_addr),
        .rd_word (rd_word),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_sdp_mixed_ram.sv
module test_sdp_mixed_ram;

    localparam int WA = 4;
    localparam int RA = 16;
    localparam int WB = 32;
    localparam int RB = 2;
    localparam logic [2:0] BA = 3'd5;
    localparam logic [2:0] BB = 3'd2;

    function automatic logic [16383:0] mk_init();
        logic [16383:0] v;
        for (int i = 0; i < 512; i++) begin
            v[i*32 +: 32] = (i * 32'h9E37_79B1) ^ 32'h5A0F_C3E1;
        end
        return v;
    endfunction

    localparam logic [16383:0] INIT_IMG = mk_init();

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;

    logic [2:0]  a_blk = BA, b_blk = BB;
    logic        a_wce = 0, a_wen = 0, a_rst = 1, a_rce = 0, a_oce = 0;
    logic        b_wce = 0, b_wen = 0, b_rst = 1, b_rce = 0, b_oce = 0;
    logic [13:0] a_waddr = 0, a_raddr = 0, b_waddr = 0, b_raddr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_dout, b_dout;

    logic [16383:0] mA = INIT_IMG;
    logic [16383:0] mB = INIT_IMG;
    logic [31:0] eA1 = 0, eB1 = 0, eB2 = 0;

    sdp_mixed_ram #(
        .WR_WIDTH(WA), .RD_WIDTH(RA), .READ_PIPE(1'b0), .ASYNC_RESET(1'b0),
        .BLOCK_ID(BA), .INIT_WORDS(INIT_IMG)
    ) i_sdp_mixed_ram (
        .blk_sel(a_blk), .wr_clk(clk), .wr_ce(a_wce), .wr_en(a_wen),
        .wr_addr(a_waddr), .wr_data(a_wdata), .rd_clk(clk), .rd_rst(a_rst),
        .rd_ce(a_rce), .rd_oce(a_oce), .rd_addr(a_raddr), .rd_data(a_dout)
    );

    sdp_mixed_ram #(
        .WR_WIDTH(WB), .RD_WIDTH(RB), .READ_PIPE(1'b1), .ASYNC_RESET(1'b1),
        .BLOCK_ID(BB), .INIT_WORDS(INIT_IMG)
    ) i_sdp_mixed_ram_pipe (
        .blk_sel(b_blk), .wr_clk(clk), .wr_ce(b_wce), .wr_en(b_wen),
        .wr_addr(b_waddr), .wr_data(b_wdata), .rd_clk(clk), .rd_rst(b_rst),
        .rd_ce(b_rce), .rd_oce(b_oce), .rd_addr(b_raddr), .rd_data(b_dout)
    );

    function automatic logic [31:0] get_bits(logic [16383:0] m, logic [13:0] a, int w);
        logic [31:0] r = '0;
        int base = (int'(a) / w) * w;
        for (int b = 0; b < w; b++) r[b] = m[base+b];
        return r;
    endfunction

    function automatic logic [16383:0] put_bits(logic [16383:0] m, logic [13:0] a,
                                                logic [31:0] d, int w);
        int base = (int'(a) / w) * w;
        for (int b = 0; b < w; b++) m[base+b] = d[b];
        return m;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // One clock: inputs were set at the previous negedge, outputs sampled at the next
    task automatic step(string req);
        @(posedge clk);
        if (a_rst) eA1 = '0;
        else if (a_rce && a_blk == BA) eA1 = get_bits(mA, a_raddr, RA);
        if (a_wce && a_wen && a_blk == BA) mA = put_bits(mA, a_waddr, a_wdata, WA);
        if (b_rst) begin
            eB1 = '0; eB2 = '0;
        end else begin
            if (b_oce) eB2 = eB1;
            if (b_rce && b_blk == BB) eB1 = get_bits(mB, b_raddr, RB);
        end
        if (b_wce && b_wen && b_blk == BB) mB = put_bits(mB, b_waddr, b_wdata, WB);
        @(negedge clk);
        chk(req, a_dout, eA1);
        chk(req, b_dout, eB2);
        chk("R9", {16'h0, a_dout[31:16]} | {2'b0, b_dout[31:2]}, 32'h0);
    endtask

    task automatic idle();
        a_wce = 0; a_wen = 0; a_rce = 0; a_oce = 0; a_blk = BA;
        b_wce = 0; b_wen = 0; b_rce = 0; b_oce = 0; b_blk = BB;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] hold;
        void'($urandom(32'd2024));
        @(negedge clk);
        // R5: reset state
        step("R5");
        chk("R5", a_dout, 32'h0);
        chk("R5", b_dout, 32'h0);
        a_rst = 0; b_rst = 0;

        // R10: untouched contents come from the init segments
        for (int i = 0; i < 40; i++) begin
            idle(); a_rce = 1; b_rce = 1; b_oce = 1;
            a_raddr = 14'($urandom); b_raddr = 14'($urandom);
            step("R10");
        end
        idle(); a_rce = 1; a_raddr = 14'h3FF0;   // last 16-bit word
        step("R10");
        chk("R10", a_dout, INIT_IMG[16383:16368]);

        // R1/R2: mixed-width traffic in a narrow window, random low address bits
        for (int i = 0; i < 400; i++) begin
            idle();
            a_wce = 1; a_wen = 1; a_waddr = 14'($urandom & 32'hFF); a_wdata = $urandom;
            a_rce = 1; a_raddr = 14'($urandom & 32'hFF);
            b_wce = 1; b_wen = 1; b_waddr = 14'($urandom & 32'h7F); b_wdata = $urandom;
            b_rce = 1; b_raddr = 14'($urandom & 32'h7F); b_oce = 1;
            step("R1");
        end
        // R2: two addresses differing only in low bits read the same word
        idle(); a_rce = 1; a_raddr = 14'h0013; step("R2");
        hold = a_dout;
        a_raddr = 14'h001C; step("R2");
        chk("R2", a_dout, hold);

        // R3: bypass latency, one edge
        idle(); a_rce = 1; a_raddr = 14'h0040; step("R3");
        chk("R3", a_dout, get_bits(mA, 14'h0040, RA));

        // R4: random output enable on the pipelined instance
        for (int i = 0; i < 200; i++) begin
            idle(); b_rce = 1; b_raddr = 14'($urandom & 32'h7F); b_oce = 1'($urandom);
            step("R4");
        end

        // R6: block mismatch blocks writes and the read load
        for (int i = 0; i < 60; i++) begin
            idle();
            a_blk = 3'($urandom % 5); b_blk = 3'(3 + $urandom % 5);
            a_wce = 1; a_wen = 1; a_waddr = 14'($urandom & 32'hFF); a_wdata = $urandom;
            a_rce = 1; a_raddr = 14'($urandom & 32'hFF);
            b_wce = 1; b_wen = 1; b_waddr = 14'($urandom & 32'h7F); b_wdata = $urandom;
            b_rce = 1; b_raddr = 14'($urandom & 32'h7F); b_oce = 1;
            step("R6");
        end

        // R7: clock enables low
        for (int i = 0; i < 60; i++) begin
            idle();
            a_wen = 1; a_waddr = 14'($urandom & 32'hFF); a_wdata = $urandom;
            a_raddr = 14'($urandom & 32'hFF);
            b_wen = 1; b_waddr = 14'($urandom & 32'h7F); b_wdata = $urandom;
            b_raddr = 14'($urandom & 32'h7F); b_oce = 1;
            step("R7");
        end

        // R11: read request on the write port writes nothing
        for (int i = 0; i < 60; i++) begin
            idle();
            a_wce = 1; a_waddr = 14'($urandom & 32'hFF); a_wdata = $urandom;
            b_wce = 1; b_waddr = 14'($urandom & 32'h7F); b_wdata = $urandom;
            step("R11");
        end
        // Read back the whole window after the R6, R7, R11 phases
        for (int i = 0; i < 256; i += 16) begin
            idle(); a_rce = 1; a_raddr = 14'(i); b_rce = 1; b_raddr = 14'(i >> 1); b_oce = 1;
            step("R11");
        end

        // R8: same address read and write in one cycle returns old data
        for (int i = 0; i < 20; i++) begin
            idle();
            a_wce = 1; a_wen = 1; a_waddr = 14'($urandom & 32'hFF);
            a_wdata = ~get_bits(mA, a_waddr, WA);
            a_rce = 1; a_raddr = a_waddr;
            hold = get_bits(mA, a_raddr, RA);
            step("R8");
            chk("R8", a_dout, hold);
            idle(); a_rce = 1;
            step("R8");
        end

        // R12 / R5: reset between edges, async clears at once, sync waits
        for (int i = 0; i < 20 && eB2 == 0; i++) begin
            idle(); b_rce = 1; b_oce = 1; b_raddr = 14'($urandom);
            a_rce = 1; a_raddr = 14'($urandom);
            step("R4");
        end
        idle();
        hold = a_dout;
        a_rst = 1; b_rst = 1;
        #1;
        chk("R12", b_dout, 32'h0);
        chk("R12", a_dout, hold);
        eB1 = '0; eB2 = '0;
        step("R5");
        a_rst = 0; b_rst = 0;
        // R5: stored contents survive the reset
        for (int i = 0; i < 256; i += 32) begin
            idle(); a_rce = 1; a_raddr = 14'(i); b_rce = 1; b_oce = 1; b_raddr = 14'(i >> 1);
            step("R5");
        end

        // Mixed random traffic with all gates random
        for (int i = 0; i < 800; i++) begin
            a_blk = ($urandom % 4 == 0) ? 3'd0 : BA;
            b_blk = ($urandom % 4 == 0) ? 3'd7 : BB;
            a_wce = 1'($urandom); a_wen = 1'($urandom); a_rce = 1'($urandom);
            a_waddr = 14'($urandom & 32'h1FF); a_raddr = 14'($urandom & 32'h1FF);
            a_wdata = $urandom;
            b_wce = 1'($urandom); b_wen = 1'($urandom); b_rce = 1'($urandom);
            b_oce = 1'($urandom);
            b_waddr = 14'($urandom & 32'h1FF); b_raddr = 14'($urandom & 32'h1FF);
            b_wdata = $urandom;
            step("R1");
        end

        finish_run();
    end

endmodule